// File: doc/BRIEF.md
# Audio Co-processor I/O Register Decoder

This block sits between the 8-bit CPU of an audio co-processor and everything that CPU reaches through its 16-bit address space. It decodes a small window of I/O addresses near the bottom page and a boot ROM window at the very top of memory. It keeps the registers that live in that window: a control register, an indirect pointer into a 128-entry sound DSP register file, the mailbox bytes exchanged with the host, two scratch bytes and three timer reload values. Any address it does not own reads from the backing 64 KiB RAM. Every CPU write is forwarded to that RAM whatever the address.

Decoding is combinational on the CPU address, so `cpu_rdata` follows the address within the same cycle. Register state changes on the rising clock edge when `cpu_wr` is high. The host fills the CPU-side input mailboxes through its own write port. The CPU fills the host-side output mailboxes, which the host sees on `mbox_to_host`. The DSP register file, the CPU core and the timer counters sit outside this block. The block only drives the timers' enable, reload and re-arm signals.

Top module: `audio_io_decoder`

## Requirements
- R1: Every CPU write, including writes to the I/O window, drives `ram_we`=1 with `ram_addr`=`cpu_addr` and `ram_wdata`=`cpu_wdata` in the same cycle.
- R2: A write to 0x00F2 loads an 8-bit DSP pointer. A read of 0x00F2 returns the stored value.
- R3: A read of 0x00F3 returns `dsp_rdata`, with `dsp_idx` equal to the low 7 bits of the pointer. A write to 0x00F3 raises `dsp_we` only when pointer bit 7 is 0. When that bit is 1, the write is dropped.
- R4: Reads of 0x00F4..0x00F7 return input mailbox 0..3. Writes to 0x00F4..0x00F7 load output mailbox 0..3, which appears on `mbox_to_host` in byte lane n (bits 8n+7:8n). The output mailboxes change only on such writes.
- R5: 0x00F8 and 0x00F9 are read/write scratch bytes.
- R6: A write to control register 0x00F1 sets `tmr_en[2:0]` from data bits 2..0. In the cycle after that write, `tmr_rearm` pulses for exactly those timers that go from disabled to enabled.
- R7: Control data bit 4 clears input mailboxes 0 and 1, and bit 5 clears input mailboxes 2 and 3. A clear wins over a host write to the same mailbox in the same cycle. The host writes input mailbox `host_sel` when `host_we`=1.
- R8: Control data bit 7 enables the boot ROM overlay. While it is on, reads of 0xFFC0..0xFFFF return ROM byte k=addr-0xFFC0, valued (0x5C + 29*k) mod 256. While it is off, those reads return RAM. A read of 0x00F1 returns 0.
- R9: Writes to 0x00FA, 0x00FB and 0x00FC load the reload values of timers 0, 1 and 2, which appear on `tmr_target` in byte lanes 0, 1 and 2.
- R10: Reset sets the pointer, all mailboxes, the scratch bytes, the timer enables and the reload values to 0, and turns the boot ROM overlay on.
- R11: Reads of any other address, including 0x00F0, 0x00FA..0x00FC and 0xFFBF, return `ram_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational on `cpu_addr` |
| ram_we | output | 1 | Backing RAM write enable |
| ram_addr | output | 16 | Backing RAM address |
| ram_wdata | output | 8 | Backing RAM write data |
| ram_rdata | input | 8 | Backing RAM read data, asynchronous |
| dsp_idx | output | 7 | DSP register index |
| dsp_we | output | 1 | DSP register write enable |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_rdata | input | 8 | DSP register read data |
| host_we | input | 1 | Host write to an input mailbox |
| host_sel | input | 2 | Input mailbox selected by the host |
| host_wdata | input | 8 | Host write data |
| mbox_to_host | output | 32 | Output mailboxes, byte lane per mailbox |
| tmr_en | output | 3 | Timer enables |
| tmr_rearm | output | 3 | One-cycle re-arm pulse per timer |
| tmr_target | output | 24 | Timer reload values, byte lane per timer |

## Verification
The bench builds the block with its default parameters: four mailboxes, two scratch bytes, three timers and a 64-byte ROM window. With these values it can reach every mailbox lane, both ends of the ROM window and the RAM address just below it, and every timer's re-arm pulse. The pointer values 0x7F and 0x80 exercise the edge of the DSP write guard. A pointer of 0x95 shows that reads drop bit 7. Issuing a mailbox clear and a host write to the same mailbox in the same cycle exposes the priority between them.

// File: rtl/aio_pkg.sv
package aio_pkg;
  localparam logic [15:0] A_CTRL  = 16'h00F1;
  localparam logic [15:0] A_DSPA  = 16'h00F2;
  localparam logic [15:0] A_DSPD  = 16'h00F3;
  localparam logic [15:0] A_PORT0 = 16'h00F4;
  localparam logic [15:0] A_TGT0  = 16'h00FA;

  // Boot ROM content, computed rather than tabulated.
  function automatic logic [7:0] boot_byte(input logic [7:0] k);
    logic [7:0] p;
    p = k * 8'd29;
    return p + 8'h5C;
  endfunction
endpackage

// File: rtl/aio_decode.sv
module aio_decode
  import aio_pkg::*;
#(
  parameter int N_PORT    = 6,
  parameter int N_TMR     = 3,
  parameter int ROM_BYTES = 64,
  localparam int PIW      = $clog2(N_PORT),
  localparam int TIW      = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic [15:0]    addr,
  output logic           hit_ctrl,
  output logic           hit_dspa,
  output logic           hit_dspd,
  output logic           hit_port,
  output logic [PIW-1:0] port_idx,
  output logic           hit_tgt,
  output logic [TIW-1:0] tgt_idx,
  output logic           in_rom_window
);
  localparam logic [15:0] ROM_BASE = 16'(65536 - ROM_BYTES);

  logic [15:0] poff, toff;

  always_comb begin
    poff          = addr - A_PORT0;
    toff          = addr - A_TGT0;
    hit_ctrl      = (addr == A_CTRL);
    hit_dspa      = (addr == A_DSPA);
    hit_dspd      = (addr == A_DSPD);
    hit_port      = (addr >= A_PORT0) && (poff < 16'(N_PORT));
    port_idx      = poff[PIW-1:0];
    hit_tgt       = (addr >= A_TGT0) && (toff < 16'(N_TMR));
    tgt_idx       = toff[TIW-1:0];
    in_rom_window = (addr >= ROM_BASE);
  end
endmodule

// File: rtl/aio_ports.sv
module aio_ports #(
  parameter int N_MBOX    = 4,
  parameter int N_SCRATCH = 2,
  localparam int N_PORT   = N_MBOX + N_SCRATCH,
  localparam int PIW      = $clog2(N_PORT),
  localparam int HSW      = $clog2(N_MBOX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_port,
  input  logic [PIW-1:0]      port_idx,
  input  logic [7:0]          wdata,
  input  logic                clr_lo,
  input  logic                clr_hi,
  input  logic                host_we,
  input  logic [HSW-1:0]      host_sel,
  input  logic [7:0]          host_wdata,
  output logic [8*N_PORT-1:0] in_flat,
  output logic [8*N_MBOX-1:0] out_flat
);
  localparam int HALF = N_MBOX / 2;

  for (genvar g = 0; g < N_PORT; g++) begin : g_in
    if (g < N_MBOX) begin : g_mbox
      logic clr;
      if (g < HALF) begin : g_lo
        assign clr = clr_lo;
      end else begin : g_hi
        assign clr = clr_hi;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  in_flat[8*g +: 8] <= '0;
        else if (clr)                                in_flat[8*g +: 8] <= '0;
        else if (host_we && host_sel == HSW'(g))     in_flat[8*g +: 8] <= host_wdata;
      end
    end else begin : g_scr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  in_flat[8*g +: 8] <= '0;
        else if (wr_port && port_idx == PIW'(g))     in_flat[8*g +: 8] <= wdata;
      end
    end
  end

  for (genvar g = 0; g < N_MBOX; g++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    out_flat[8*g +: 8] <= '0;
      else if (wr_port && port_idx == PIW'(g))       out_flat[8*g +: 8] <= wdata;
    end
  end
endmodule

// File: rtl/aio_ctrl.sv
module aio_ctrl #(
  parameter int N_TMR = 3,
  localparam int TIW  = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic               wr_dspa,
  input  logic               wr_tgt,
  input  logic [TIW-1:0]     tgt_idx,
  input  logic [7:0]         wdata,
  output logic [7:0]         dsp_latch,
  output logic               rom_en,
  output logic [N_TMR-1:0]   tmr_en,
  output logic [N_TMR-1:0]   tmr_rearm,
  output logic [8*N_TMR-1:0] tgt_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsp_latch <= '0;
      rom_en    <= 1'b1;
      tmr_en    <= '0;
      tmr_rearm <= '0;
    end else begin
      if (wr_dspa) dsp_latch <= wdata;
      if (wr_ctrl) begin
        rom_en <= wdata[7];
        tmr_en <= wdata[N_TMR-1:0];
      end
      tmr_rearm <= wr_ctrl ? (wdata[N_TMR-1:0] & ~tmr_en) : '0;
    end
  end

  for (genvar t = 0; t < N_TMR; t++) begin : g_tgt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             tgt_flat[8*t +: 8] <= '0;
      else if (wr_tgt && tgt_idx == TIW'(t))  tgt_flat[8*t +: 8] <= wdata;
    end
  end
endmodule

// File: rtl/audio_io_decoder.sv
module audio_io_decoder
  import aio_pkg::*;
#(
  parameter int N_MBOX    = 4,
  parameter int N_SCRATCH = 2,
  parameter int N_TMR     = 3,
  parameter int ROM_BYTES = 64,
  localparam int HSW      = $clog2(N_MBOX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         cpu_addr,
  input  logic                cpu_wr,
  input  logic [7:0]          cpu_wdata,
  output logic [7:0]          cpu_rdata,
  output logic                ram_we,
  output logic [15:0]         ram_addr,
  output logic [7:0]          ram_wdata,
  input  logic [7:0]          ram_rdata,
  output logic [6:0]          dsp_idx,
  output logic                dsp_we,
  output logic [7:0]          dsp_wdata,
  input  logic [7:0]          dsp_rdata,
  input  logic                host_we,
  input  logic [HSW-1:0]      host_sel,
  input  logic [7:0]          host_wdata,
  output logic [8*N_MBOX-1:0] mbox_to_host,
  output logic [N_TMR-1:0]    tmr_en,
  output logic [N_TMR-1:0]    tmr_rearm,
  output logic [8*N_TMR-1:0]  tmr_target
);
  localparam int N_PORT = N_MBOX + N_SCRATCH;
  localparam int PIW    = $clog2(N_PORT);
  localparam int TIW    = (N_TMR > 1) ? $clog2(N_TMR) : 1;
  localparam int ROM_AW = $clog2(ROM_BYTES);

  logic           hit_ctrl, hit_dspa, hit_dspd, hit_port, hit_tgt, in_rom_window;
  logic [PIW-1:0] port_idx;
  logic [TIW-1:0] tgt_idx;

  // Named events shared by the datapath and the checker.
  logic wr_ctrl, wr_dspa, wr_dspd, wr_port, wr_tgt, rom_hit, clr_lo, clr_hi;
  logic rom_en;
  logic [7:0] dsp_latch;
  logic [8*N_PORT-1:0] in_flat;

  aio_decode #(.N_PORT(N_PORT), .N_TMR(N_TMR), .ROM_BYTES(ROM_BYTES)) u_dec (
    .addr(cpu_addr), .hit_ctrl(hit_ctrl), .hit_dspa(hit_dspa), .hit_dspd(hit_dspd),
    .hit_port(hit_port), .port_idx(port_idx), .hit_tgt(hit_tgt), .tgt_idx(tgt_idx),
    .in_rom_window(in_rom_window)
  );

  assign wr_ctrl = cpu_wr & hit_ctrl;
  assign wr_dspa = cpu_wr & hit_dspa;
  assign wr_dspd = cpu_wr & hit_dspd;
  assign wr_port = cpu_wr & hit_port;
  assign wr_tgt  = cpu_wr & hit_tgt;
  assign clr_lo  = wr_ctrl & cpu_wdata[4];
  assign clr_hi  = wr_ctrl & cpu_wdata[5];
  assign rom_hit = rom_en & in_rom_window;

  aio_ports #(.N_MBOX(N_MBOX), .N_SCRATCH(N_SCRATCH)) u_ports (
    .clk(clk), .rst_n(rst_n), .wr_port(wr_port), .port_idx(port_idx), .wdata(cpu_wdata),
    .clr_lo(clr_lo), .clr_hi(clr_hi), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .in_flat(in_flat), .out_flat(mbox_to_host)
  );

  aio_ctrl #(.N_TMR(N_TMR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_dspa(wr_dspa), .wr_tgt(wr_tgt),
    .tgt_idx(tgt_idx), .wdata(cpu_wdata), .dsp_latch(dsp_latch), .rom_en(rom_en),
    .tmr_en(tmr_en), .tmr_rearm(tmr_rearm), .tgt_flat(tmr_target)
  );

  assign ram_we    = cpu_wr;
  assign ram_addr  = cpu_addr;
  assign ram_wdata = cpu_wdata;
  assign dsp_idx   = dsp_latch[6:0];
  assign dsp_we    = wr_dspd & ~dsp_latch[7];
  assign dsp_wdata = cpu_wdata;

  always_comb begin
    cpu_rdata = ram_rdata;
    if (hit_ctrl)      cpu_rdata = '0;
    else if (hit_dspa) cpu_rdata = dsp_latch;
    else if (hit_dspd) cpu_rdata = dsp_rdata;
    else if (hit_port) cpu_rdata = in_flat[{port_idx, 3'b000} +: 8];
    else if (rom_hit)  cpu_rdata = boot_byte(8'(cpu_addr[ROM_AW-1:0]));
  end
endmodule

// File: rtl/aio_chk.sv
module aio_chk #(
  parameter int N_MBOX = 4,
  parameter int N_TMR  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [15:0]         cpu_addr,
  input logic                cpu_wr,
  input logic [7:0]          cpu_wdata,
  input logic                ram_we,
  input logic [15:0]         ram_addr,
  input logic [7:0]          ram_wdata,
  input logic [6:0]          dsp_idx,
  input logic                dsp_we,
  input logic [7:0]          dsp_latch,
  input logic [8*N_MBOX-1:0] mbox_to_host,
  input logic [N_TMR-1:0]    tmr_en,
  input logic [N_TMR-1:0]    tmr_rearm,
  input logic                rom_en
);
  assert_ram_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> ram_we && ram_addr == cpu_addr && ram_wdata == cpu_wdata);

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr == 16'h00F2 |=> dsp_latch == $past(cpu_wdata) && dsp_idx == $past(cpu_wdata[6:0]));

  assert_dsp_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_we |-> cpu_wr && cpu_addr == 16'h00F3 && !dsp_latch[7]);

  assert_outbox_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr == 16'h00F4 |=> mbox_to_host[7:0] == $past(cpu_wdata));

  assert_outbox_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(mbox_to_host));

  assert_tmr_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr == 16'h00F1 |=> tmr_en == $past(cpu_wdata[N_TMR-1:0]));

  assert_rearm_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_rearm & ~tmr_en) == '0);

  assert_overlay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr == 16'h00F1 |=> rom_en == $past(cpu_wdata[7]));
endmodule

bind audio_io_decoder aio_chk #(.N_MBOX(N_MBOX), .N_TMR(N_TMR)) u_chk (.*);

// File: tb/audio_io_decoder_bench.sv
module audio_io_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [6:0]  dsp_idx;
  logic        dsp_we;
  logic [7:0]  dsp_wdata, dsp_rdata;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [7:0]  host_wdata = '0;
  logic [31:0] mbox_to_host;
  logic [2:0]  tmr_en, tmr_rearm;
  logic [23:0] tmr_target;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] ram_pat(input logic [15:0] a); return a[15:8] ^ a[7:0]; endfunction
  function automatic logic [7:0] dsp_pat(input logic [6:0] i); return 8'h40 + {1'b0, i}; endfunction
  function automatic logic [7:0] rom_pat(input int k);
    int v;
    v = (92 + 29 * k) % 256;
    return v[7:0];
  endfunction

  assign ram_rdata = ram_pat(ram_addr);
  assign dsp_rdata = dsp_pat(dsp_idx);

  audio_io_decoder u_audio_io_decoder (.*);

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [17] = '{
    '{1'b0, 16'h1234, 8'h00, 8'h26, 8'd11},  // R11 plain RAM
    '{1'b1, 16'h00F2, 8'h15, 8'h00, 8'd2},
    '{1'b0, 16'h00F2, 8'h00, 8'h15, 8'd2},   // R2 pointer readback
    '{1'b0, 16'h00F3, 8'h00, 8'h55, 8'd3},   // R3 window read
    '{1'b1, 16'h00F2, 8'h95, 8'h00, 8'd2},
    '{1'b0, 16'h00F2, 8'h00, 8'h95, 8'd2},   // R2
    '{1'b0, 16'h00F3, 8'h00, 8'h55, 8'd3},   // R3 bit 7 dropped
    '{1'b1, 16'h00F8, 8'h3C, 8'h00, 8'd5},
    '{1'b1, 16'h00F9, 8'hC3, 8'h00, 8'd5},
    '{1'b0, 16'h00F8, 8'h00, 8'h3C, 8'd5},   // R5 scratch
    '{1'b0, 16'h00F9, 8'h00, 8'hC3, 8'd5},   // R5
    '{1'b0, 16'h00F1, 8'h00, 8'h00, 8'd8},   // R8 control reads 0
    '{1'b0, 16'h00FA, 8'h00, 8'hFA, 8'd11},  // R11
    '{1'b0, 16'hFFC0, 8'h00, 8'h5C, 8'd8},   // R8 ROM first byte
    '{1'b0, 16'hFFFF, 8'h00, 8'h7F, 8'd8},   // R8 ROM last byte
    '{1'b0, 16'hFFBF, 8'h00, 8'h40, 8'd11},  // R11 below window
    '{1'b0, 16'h00F0, 8'h00, 8'hF0, 8'd11}   // R11
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0;
    #1 chk(tag, {24'd0, cpu_rdata}, {24'd0, exp});
  endtask

  task automatic reset_checks(input string tag);
    rd(16'h00F2, 8'h00, tag);
    for (int p = 0; p < 6; p++) rd(16'h00F4 + 16'(p), 8'h00, tag);
    rd(16'hFFC0, rom_pat(0), tag);
    chk(tag, mbox_to_host, 32'h0);
    chk(tag, {29'd0, tmr_en}, 32'h0);
    chk(tag, {8'd0, tmr_target}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_checks("R10 reset state");

    foreach (VECS[i]) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else rd(VECS[i].addr, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R1 write mirror on an I/O address and a RAM address; R4 output lane 1
    @(negedge clk);
    cpu_addr = 16'h00F5; cpu_wdata = 8'h77; cpu_wr = 1'b1;
    #1 chk("R1 io write", {ram_we, ram_addr, ram_wdata}, {7'd0, 1'b1, 16'h00F5, 8'h77});
    @(negedge clk);
    cpu_addr = 16'h2000; cpu_wdata = 8'hAB;
    #1 chk("R1 ram write", {ram_we, ram_addr, ram_wdata}, {7'd0, 1'b1, 16'h2000, 8'hAB});
    @(negedge clk);
    cpu_wr = 1'b0;
    chk("R4 out lane 1", mbox_to_host, 32'h0000_7700);
    wr(16'h00F7, 8'hE1);
    chk("R4 out lane 3", mbox_to_host, 32'hE100_7700);
    rd(16'h00F5, 8'h00, "R4 input port unaffected by CPU write");

    // R3 write guard (pointer is 0x95)
    @(negedge clk);
    cpu_addr = 16'h00F3; cpu_wdata = 8'h10; cpu_wr = 1'b1;
    #1 chk("R3 guard 0x95", {31'd0, dsp_we}, 32'd0);
    @(negedge clk); cpu_wr = 1'b0;
    wr(16'h00F2, 8'h7F);
    @(negedge clk);
    cpu_addr = 16'h00F3; cpu_wdata = 8'h10; cpu_wr = 1'b1;
    #1 chk("R3 write 0x7F", {23'd0, dsp_we, dsp_idx, dsp_wdata}, {23'd0, 1'b1, 7'h7F, 8'h10});
    @(negedge clk); cpu_wr = 1'b0;
    wr(16'h00F2, 8'h80);
    @(negedge clk);
    cpu_addr = 16'h00F3; cpu_wr = 1'b1;
    #1 chk("R3 guard 0x80", {31'd0, dsp_we}, 32'd0);
    @(negedge clk); cpu_wr = 1'b0;

    // R4/R7 host-written input mailboxes
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      host_we = 1'b1; host_sel = 2'(p); host_wdata = 8'hA0 + 8'(p);
    end
    @(negedge clk); host_we = 1'b0;
    for (int p = 0; p < 4; p++) rd(16'h00F4 + 16'(p), 8'hA0 + 8'(p), "R4 host input");

    // R7 clear low pair, keep overlay on; clear wins over host write to port 1
    @(negedge clk);
    cpu_addr = 16'h00F1; cpu_wdata = 8'h90; cpu_wr = 1'b1;
    host_we = 1'b1; host_sel = 2'd1; host_wdata = 8'h55;
    @(negedge clk);
    cpu_wr = 1'b0; host_we = 1'b0;
    rd(16'h00F4, 8'h00, "R7 clear port 0");
    rd(16'h00F5, 8'h00, "R7 clear beats host write");
    rd(16'h00F6, 8'hA2, "R7 port 2 kept");
    rd(16'h00F8, 8'h3C, "R7 scratch kept");
    wr(16'h00F1, 8'hA0);
    rd(16'h00F7, 8'h00, "R7 clear port 3");

    // R6 timer enables and re-arm pulses
    wr(16'h00F1, 8'h83);
    chk("R6 enable", {26'd0, tmr_en, tmr_rearm}, {26'd0, 3'b011, 3'b011});
    @(negedge clk);
    chk("R6 pulse ends", {29'd0, tmr_rearm}, 32'd0);
    wr(16'h00F1, 8'h87);
    chk("R6 only new timer", {26'd0, tmr_en, tmr_rearm}, {26'd0, 3'b111, 3'b100});

    // R9 reload values
    wr(16'h00FA, 8'h11);
    wr(16'h00FB, 8'h22);
    wr(16'h00FC, 8'h33);
    chk("R9 targets", {8'd0, tmr_target}, 32'h0033_2211);

    // R8 overlay off then on
    wr(16'h00F1, 8'h00);
    rd(16'hFFC0, ram_pat(16'hFFC0), "R8 overlay off");
    wr(16'h00F1, 8'h80);
    rd(16'hFFE5, rom_pat(37), "R8 overlay on");

    // R10 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    reset_checks("R10 second reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule